// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Committed Updates

This block drives four pulse-width modulated outputs from a small word-addressed register interface. Each channel has a control word, a period length, a phase word and an active-time length. A single global word holds the channel enable bits and a commit request bit. Software programs new settings freely. Only the commit request moves them into the running channels, so a waveform in progress is never cut short or stretched.

Each channel takes the committed settings at its own period boundary. A channel that is not currently running takes them on the next clock. The commit bit stays visible as set until every channel has taken the new settings, and then it clears itself. Software can therefore poll it to learn when a reconfiguration is complete. The only waveform generated is trailing-edge mark/space: the output is active from the start of each period for the programmed number of cycles, and polarity can be inverted per channel.

Top module: `pwm_bank`

## Requirements
- R1: After reset the global word reads 0, every channel control word reads 0x00000101, every period, phase and active-time word reads 0, and all four outputs are low.
- R2: The global word is at 0x000. Channel n (0..3) has its control word at 0x014+16n, its period at 0x018+16n, its phase at 0x01C+16n and its active time at 0x020+16n. The control word keeps all 32 bits. The period, phase and active-time words keep their low 16 bits and read zero above them. Global bits [3:0] are the channel enables and read back as written.
- R3: Any other address, including a non-word-aligned one, reads as zero, and a write to it changes no register.
- R4: Writes to channel words or to the enable bits do not change any output until a commit is requested.
- R5: Writing the global word with bit 31 set requests a commit. Bit 31 reads 1 from the next clock until every channel has taken the new settings, and then reads 0 without further writes.
- R6: A running channel takes committed settings on the clock at the end of its current period. A channel that is not running takes them on the next clock. In both cases the channel's counter restarts at 0.
- R7: A running channel counts 0 to period−1 and is active while the count is below the active time. An active time of period or more gives a constant active level. A period of 0 or 1 is treated as a one-cycle period.
- R8: Control bit 3 set inverts the output: the active level becomes 0 and the idle level becomes 1.
- R9: A channel whose enable bit is 0, or whose control bits [1:0] are 0, drives its idle level (0, or 1 when inverted).
- R10: Control bits [1:0] equal to 2 or 3 behave as off, exactly like 0.
- R11: The phase word and control bit 8 are stored and read back but do not change the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, one register per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pwm_out | output | 4 | Channel outputs, bit n is channel n |

## Verification
A reference model of the registers and channels predicts every output bit on every clock, and the value of every read. The stimulus covers several kinds of change. Shadow-only writes without a commit show whether anything leaks through early. A commit issued mid-period on a running channel shows whether the boundary is respected rather than an immediate load. Active times at, above and below the period, and periods of 0 and 1, show whether the compare and wrap are off by one. Inversion, disable through the enable bit, and off through each mode value show whether the idle level follows polarity. Reads of unused and misaligned addresses after writes to them, and phase and bit-8 changes, show stray decodes and unwanted side effects.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
package pwm_pkg;
  localparam int N_CH      = 4;
  localparam int ADDR_W    = 12;
  localparam int DATA_W    = 32;
  localparam int CNT_W_DEF = 16;
  localparam logic [DATA_W-1:0] CTL_RST = 32'h0000_0101;
  localparam logic [ADDR_W-1:0] GLB_ADDR = 12'h000;
  localparam logic [ADDR_W-1:0] CH_BASE  = 12'h014;
  localparam logic [ADDR_W-1:0] CH_END   = 12'h054;
  localparam int COMMIT_BIT = 31;
  localparam int INV_BIT    = 3;

  typedef enum logic [1:0] {MODE_OFF = 2'd0, MODE_TRAIL = 2'd1,
                            MODE_RSV2 = 2'd2, MODE_RSV3 = 2'd3} pwm_mode_e;
  typedef enum logic [1:0] {SEL_CTL = 2'd0, SEL_PER = 2'd1,
                            SEL_PHS = 2'd2, SEL_ACT = 2'd3} reg_sel_e;

  function automatic logic chan_hit(logic [ADDR_W-1:0] a);
    return (a >= CH_BASE) && (a < CH_END) && (a[1:0] == 2'b00);
  endfunction

  function automatic logic [1:0] chan_idx(logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] off;
    off = a - CH_BASE;
    return off[5:4];
  endfunction

  function automatic reg_sel_e chan_sel(logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] off;
    off = a - CH_BASE;
    return reg_sel_e'(off[3:2]);
  endfunction
endpackage

// File: rtl/pwm_csr.sv
`timescale 1ns/1ps
module pwm_csr
  import pwm_pkg::*;
#(
  parameter int CNT_W = CNT_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_CH-1:0]   pend_i,
  output logic              commit_o,
  output logic [N_CH-1:0]   en_o,
  output logic [DATA_W-1:0] ctl_o   [N_CH],
  output logic [CNT_W-1:0]  per_o   [N_CH],
  output logic [CNT_W-1:0]  act_o   [N_CH]
);
  logic [CNT_W-1:0] phs_q [N_CH];
  logic             glb_wr;

  assign glb_wr   = wr_i && (addr_i == GLB_ADDR);
  assign commit_o = glb_wr && wdata_i[COMMIT_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_o <= '0;
    else if (glb_wr) en_o <= wdata_i[N_CH-1:0];
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic ch_wr;
    assign ch_wr = wr_i && chan_hit(addr_i) && (chan_idx(addr_i) == 2'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl_o[g] <= CTL_RST;
        per_o[g] <= '0;
        phs_q[g] <= '0;
        act_o[g] <= '0;
      end else if (ch_wr) begin
        case (chan_sel(addr_i))
          SEL_CTL: ctl_o[g] <= wdata_i;
          SEL_PER: per_o[g] <= wdata_i[CNT_W-1:0];
          SEL_PHS: phs_q[g] <= wdata_i[CNT_W-1:0];
          SEL_ACT: act_o[g] <= wdata_i[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == GLB_ADDR) begin
      rdata_o[N_CH-1:0]   = en_o;
      rdata_o[COMMIT_BIT] = |pend_i;
    end else if (chan_hit(addr_i)) begin
      case (chan_sel(addr_i))
        SEL_CTL: rdata_o = ctl_o[chan_idx(addr_i)];
        SEL_PER: rdata_o = DATA_W'(per_o[chan_idx(addr_i)]);
        SEL_PHS: rdata_o = DATA_W'(phs_q[chan_idx(addr_i)]);
        SEL_ACT: rdata_o = DATA_W'(act_o[chan_idx(addr_i)]);
        default: rdata_o = '0;
      endcase
    end
  end

  // R5
  commit_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> (|pend_i));
endmodule

// File: rtl/pwm_chan.sv
`timescale 1ns/1ps
module pwm_chan
  import pwm_pkg::*;
#(
  parameter int CNT_W = CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_i,
  input  logic             sh_en_i,
  input  logic [1:0]       sh_mode_i,
  input  logic             sh_inv_i,
  input  logic [CNT_W-1:0] sh_per_i,
  input  logic [CNT_W-1:0] sh_act_i,
  output logic             pend_o,
  output logic             pwm_o
);
  logic             live_en, live_inv;
  pwm_mode_e        live_mode;
  logic [CNT_W-1:0] live_per, live_act, cnt_q;
  logic             running, period_end, take, mark;

  function automatic logic last_tick(logic [CNT_W-1:0] c, logic [CNT_W-1:0] p);
    return (p <= CNT_W'(1)) || (c == p - CNT_W'(1));
  endfunction

  assign running    = live_en && (live_mode == MODE_TRAIL);
  assign period_end = !running || last_tick(cnt_q, live_per);
  assign take       = pend_o && period_end;
  assign mark       = running && (cnt_q < live_act);
  assign pwm_o      = mark ^ live_inv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend_o <= 1'b0;
    else if (commit_i) pend_o <= 1'b1;
    else if (take)     pend_o <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_en   <= 1'b0;
      live_inv  <= 1'b0;
      live_mode <= MODE_OFF;
      live_per  <= '0;
      live_act  <= '0;
    end else if (take) begin
      live_en   <= sh_en_i;
      live_inv  <= sh_inv_i;
      live_mode <= pwm_mode_e'(sh_mode_i);
      live_per  <= sh_per_i;
      live_act  <= sh_act_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (take || period_end)  cnt_q <= '0;
    else                          cnt_q <= cnt_q + CNT_W'(1);
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && live_per > CNT_W'(1)) |-> (cnt_q < live_per));
  // R7
  full_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && live_act >= live_per && live_act != '0) |-> (pwm_o == !live_inv));
  // R9
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (pwm_o == live_inv));
  // R6
  load_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(live_per) |-> $past(take));
  // R5
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_o) |-> $past(take));
endmodule

// File: rtl/pwm_bank.sv
`timescale 1ns/1ps
module pwm_bank
  import pwm_pkg::*;
#(
  parameter int CNT_W = CNT_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [N_CH-1:0]   pwm_out
);
  logic              commit;
  logic [N_CH-1:0]   en_sh, pend;
  logic [DATA_W-1:0] ctl_sh [N_CH];
  logic [CNT_W-1:0]  per_sh [N_CH];
  logic [CNT_W-1:0]  act_sh [N_CH];

  pwm_csr #(.CNT_W(CNT_W)) u_csr (
    .clk(clk), .rst_n(rst_n), .addr_i(reg_addr), .wr_i(reg_wr),
    .wdata_i(reg_wdata), .rdata_o(reg_rdata), .pend_i(pend),
    .commit_o(commit), .en_o(en_sh), .ctl_o(ctl_sh), .per_o(per_sh),
    .act_o(act_sh)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_chan
    pwm_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .commit_i(commit), .sh_en_i(en_sh[g]),
      .sh_mode_i(ctl_sh[g][1:0]), .sh_inv_i(ctl_sh[g][INV_BIT]),
      .sh_per_i(per_sh[g]), .sh_act_i(act_sh[g]),
      .pend_o(pend[g]), .pwm_o(pwm_out[g])
    );
  end
endmodule

// File: tb/pwm_bank_tb_top.sv
`timescale 1ns/1ps
module pwm_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] reg_addr;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [3:0]  pwm_out;

  always #10 clk = ~clk;

  pwm_bank dut_i (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
                  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out));

  int    n_tests = 0, n_fail = 0;
  string cur_req = "R1";
  bit    done = 0;

  // reference model state
  logic [3:0]  m_en;
  logic [31:0] m_ctl [4];
  logic [15:0] m_per [4], m_phs [4], m_act [4];
  logic        m_pend [4];
  logic        l_en [4], l_inv [4];
  logic [1:0]  l_mode [4];
  int          l_per [4], l_act [4], m_pos [4];
  logic        m_commit;

  function automatic bit live_on(int n);
    return l_en[n] && (l_mode[n] == 2'd1);
  endfunction

  function automatic logic [3:0] m_out();
    logic [3:0] o;
    for (int n = 0; n < 4; n++)
      o[n] = (live_on(n) && (m_pos[n] < l_act[n])) ? ~l_inv[n] : l_inv[n];
    return o;
  endfunction

  function automatic logic [31:0] m_read(logic [11:0] a);
    if (a == 12'h000)
      return {m_pend[0] | m_pend[1] | m_pend[2] | m_pend[3], 27'b0, m_en};
    for (int n = 0; n < 4; n++) begin
      if (a == 12'h014 + 12'(n * 16)) return m_ctl[n];
      if (a == 12'h018 + 12'(n * 16)) return {16'b0, m_per[n]};
      if (a == 12'h01C + 12'(n * 16)) return {16'b0, m_phs[n]};
      if (a == 12'h020 + 12'(n * 16)) return {16'b0, m_act[n]};
    end
    return 32'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = '0;
      for (int n = 0; n < 4; n++) begin
        m_ctl[n] = 32'h101; m_per[n] = 0; m_phs[n] = 0; m_act[n] = 0;
        m_pend[n] = 0; l_en[n] = 0; l_inv[n] = 0; l_mode[n] = 0;
        l_per[n] = 0; l_act[n] = 0; m_pos[n] = 0;
      end
    end else begin
      m_commit = reg_wr && (reg_addr == 12'h000) && reg_wdata[31];
      for (int n = 0; n < 4; n++) begin
        int  len;
        bit  last;
        len  = (l_per[n] < 1) ? 1 : l_per[n];
        last = !live_on(n) || (m_pos[n] == len - 1);
        if (m_pend[n] && last) begin
          l_en[n] = m_en[n]; l_inv[n] = m_ctl[n][3]; l_mode[n] = m_ctl[n][1:0];
          l_per[n] = int'(m_per[n]); l_act[n] = int'(m_act[n]);
          m_pos[n] = 0;
          m_pend[n] = m_commit;
        end else begin
          m_pos[n] = last ? 0 : m_pos[n] + 1;
          if (m_commit) m_pend[n] = 1;
        end
      end
      if (reg_wr) begin
        if (reg_addr == 12'h000) m_en = reg_wdata[3:0];
        for (int n = 0; n < 4; n++) begin
          if (reg_addr == 12'h014 + 12'(n * 16)) m_ctl[n] = reg_wdata;
          if (reg_addr == 12'h018 + 12'(n * 16)) m_per[n] = reg_wdata[15:0];
          if (reg_addr == 12'h01C + 12'(n * 16)) m_phs[n] = reg_wdata[15:0];
          if (reg_addr == 12'h020 + 12'(n * 16)) m_act[n] = reg_wdata[15:0];
        end
      end
    end
  end

  // scoreboard
  typedef struct {logic [31:0] exp; string req; logic [11:0] a;} rd_item_t;
  rd_item_t rq[$];
  rd_item_t it;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #5;
    if (rst_n) chk(cur_req, "pwm_out", {28'b0, pwm_out}, {28'b0, m_out()});
    while (rq.size() > 0) begin
      it = rq.pop_front();
      chk(it.req, $sformatf("read %h", it.a), reg_rdata, it.exp);
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, string req);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b0;
    rq.push_back('{m_read(a), req, a});
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [11:0] ca(int n, int r);
    return 12'h014 + 12'(n * 16) + 12'(r * 4);
  endfunction

  initial begin
    rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    cur_req = "R1";
    rd(12'h000, "R1");
    for (int n = 0; n < 4; n++)
      for (int r = 0; r < 4; r++) rd(ca(n, r), "R1");
    // R2 map and widths
    cur_req = "R2";
    wr(ca(1, 1), 32'h1234_5678); rd(ca(1, 1), "R2");
    wr(ca(2, 2), 32'h0000_ABCD); rd(ca(2, 2), "R2");
    wr(ca(3, 3), 32'hFFFF_0042); rd(ca(3, 3), "R2");
    wr(ca(0, 0), 32'hDEAD_0109); rd(ca(0, 0), "R2");
    wr(12'h000, 32'h0000_000A);  rd(12'h000, "R2");
    wr(ca(0, 0), 32'h0000_0101); wr(12'h000, 32'h0);
    // R3 unmapped
    cur_req = "R3";
    wr(12'h004, 32'hFFFF_FFFF); wr(12'h054, 32'hFFFF_FFFF);
    wr(12'h016, 32'hFFFF_FFFF); wr(12'h0FC, 32'hFFFF_FFFF);
    rd(12'h004, "R3"); rd(12'h054, "R3"); rd(12'h016, "R3"); rd(12'h0FC, "R3");
    rd(ca(0, 0), "R3"); rd(ca(0, 1), "R3"); rd(12'h000, "R3");
    // R4 shadow only
    cur_req = "R4";
    wr(ca(0, 1), 10); wr(ca(0, 3), 3); wr(12'h000, 32'h1);
    idle(15);
    // R5 commit flag
    cur_req = "R5";
    wr(12'h000, 32'h8000_0001); rd(12'h000, "R5"); idle(2); rd(12'h000, "R5");
    cur_req = "R7";
    idle(25);
    // R6 mid-period commit on running channel
    cur_req = "R6";
    idle(3);
    wr(ca(0, 3), 7); wr(12'h000, 32'h8000_0001);
    rd(12'h000, "R6"); rd(12'h000, "R6");
    idle(25); rd(12'h000, "R6");
    // R7 boundary lengths
    cur_req = "R7";
    wr(ca(0, 3), 10); wr(12'h000, 32'h8000_0001); idle(25);
    wr(ca(1, 1), 1); wr(ca(1, 3), 1); wr(ca(1, 0), 32'h1);
    wr(ca(2, 1), 0); wr(ca(2, 3), 0); wr(ca(2, 0), 32'h1);
    wr(12'h000, 32'h8000_0007); idle(12);
    wr(ca(0, 3), 12); wr(12'h000, 32'h8000_0007); idle(25);
    // R8 inversion
    cur_req = "R8";
    wr(ca(1, 0), 32'h9); wr(ca(1, 1), 6); wr(ca(1, 3), 2);
    wr(12'h000, 32'h8000_0003); idle(20);
    // R9 disable and mode 0
    cur_req = "R9";
    wr(12'h000, 32'h8000_0002); idle(15);
    wr(ca(2, 0), 32'h8); wr(12'h000, 32'h8000_0006); idle(10);
    // R10 reserved modes
    cur_req = "R10";
    wr(ca(3, 0), 32'h2); wr(ca(3, 1), 5); wr(ca(3, 3), 2);
    wr(12'h000, 32'h8000_000E); idle(10);
    wr(ca(3, 0), 32'h3); wr(12'h000, 32'h8000_000E); idle(10);
    wr(ca(3, 0), 32'h101); wr(12'h000, 32'h8000_000E); idle(12);
    // R11 phase and bit 8 inert
    cur_req = "R11";
    wr(ca(3, 2), 3); wr(ca(3, 0), 32'h1); wr(12'h000, 32'h8000_000E); idle(12);
    rd(ca(3, 2), "R11"); rd(ca(3, 0), "R11");
    idle(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule